// File: doc/BRIEF.md
# Presettable Down Counter Stage

This block is a binary down counter, eight bits wide by default, that raises an active-low terminal flag when its count is zero and counting is enabled. Every control is active-low. The controls are a count enable, which also serves as the cascade input, a synchronous parallel load, an asynchronous parallel load, and an asynchronous clear that drives the count to all ones. The internal count is brought out so that it can be observed.

On each rising clock edge the synchronous part takes one of three steps. STEP_LOAD captures the preset word. It is taken when the synchronous load is low, whatever the enable does. STEP_DEC subtracts one and is taken when only the enable is low. STEP_HOLD keeps the value and is taken when the enable is high. The visible count has three sources. VIEW_MAX (all ones) is chosen while clear is low. VIEW_PRESET (the live preset word) is chosen while the asynchronous load is low. VIEW_REG (the stored count) is chosen otherwise. The transitions are fixed by priority: clear over asynchronous load, asynchronous load over synchronous load, synchronous load over count.

To build a longer counter, feed the terminal output of one stage into the enable of the next stage. Both stages use the same clock.

Top module: `dcnt_stage`

## Requirements
- R1: While clr_n is 0, count_o equals all ones (255) immediately and stays there, whatever the other inputs do.
- R2: With clr_n, aload_n and sload_n at 1 and en_n at 0, each rising clock edge lowers count_o by one.
- R3: With clr_n, aload_n and sload_n at 1 and en_n at 1, count_o does not change across clock edges.
- R4: With clr_n and aload_n at 1 and sload_n at 0, the next rising edge loads preset_i into count_o, whether en_n is 0 or 1.
- R5: While aload_n is 0 and clr_n is 1, count_o equals preset_i at once and follows changes to preset_i, ignoring the clock, en_n and sload_n. After release, the count keeps the preset word it held when the last clock edge occurred.
- R6: The priority is fixed: clr_n over aload_n, aload_n over sload_n, sload_n over en_n.
- R7: tc_n is 0 exactly when count_o is 0 and en_n is 0. It responds combinationally, with no clock edge, to en_n, loads and clear.
- R8: A zero count with only en_n active wraps to 255 on the next edge. Free-running gives one tc_n low cycle every 256 clocks.
- R9: Two stages, where the tc_n of the first drives the en_n of the second, repeat their combined terminal pulse every 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to all ones, active low |
| aload_n | input | 1 | Asynchronous parallel load, active low |
| sload_n | input | 1 | Synchronous parallel load, active low |
| en_n | input | 1 | Count enable and cascade input, active low |
| preset_i | input | W | Parallel preset word |
| tc_n | output | 1 | Terminal count (zero and enabled), active low |
| count_o | output | W | Current count value |

## Verification
The clear, the asynchronous load and tc_n take effect with no clock edge, so the bench checks them a fraction of a nanosecond after the input changes, before any edge can occur. The synchronous load, decrement and wrap complete on the first rising edge after the controls are set. The bench drives inputs 1 ns after an edge. It compares a behavioural reference model with both outputs at every falling edge, which is half a period after the register update. Wrap and cascade periods are measured by counting falling-edge samples between terminal pulses.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_LOAD = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        VIEW_REG    = 2'd0,
        VIEW_PRESET = 2'd1,
        VIEW_MAX    = 2'd2
    } view_e;
endpackage

// File: rtl/dcnt_mode_dec.sv
module dcnt_mode_dec
    import dcnt_pkg::*;
(
    input  logic  clr_n,
    input  logic  aload_n,
    input  logic  sload_n,
    input  logic  en_n,
    output step_e step,
    output view_e view
);
    // Synchronous step: load beats count, count beats hold
    always_comb begin
        step = STEP_HOLD;
        unique casez ({sload_n, en_n})
            2'b0?:   step = STEP_LOAD;
            2'b10:   step = STEP_DEC;
            2'b11:   step = STEP_HOLD;
            default: step = STEP_HOLD;
        endcase
    end

    // Visible source: clear beats asynchronous load
    always_comb begin
        view = VIEW_REG;
        unique casez ({clr_n, aload_n})
            2'b0?:   view = VIEW_MAX;
            2'b10:   view = VIEW_PRESET;
            2'b11:   view = VIEW_REG;
            default: view = VIEW_REG;
        endcase
    end
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
    import dcnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         aload_n,
    input  step_e        step,
    input  view_e        view,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    // Next-state selection for the synchronous step
    always_comb begin
        cnt_nxt = cnt_q;
        unique case (step)
            STEP_LOAD: cnt_nxt = preset_i;
            STEP_DEC:  cnt_nxt = cnt_q - ONE;
            STEP_HOLD: cnt_nxt = cnt_q;
            default:   cnt_nxt = cnt_q;
        endcase
    end

    // State register with asynchronous clear and asynchronous load
    always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n)
            cnt_q <= MAXV;
        else if (!aload_n)
            cnt_q <= preset_i;
        else
            cnt_q <= cnt_nxt;
    end

    // Output source: live overrides while the asynchronous inputs are held
    always_comb begin
        cnt_o = cnt_q;
        unique case (view)
            VIEW_MAX:    cnt_o = MAXV;
            VIEW_PRESET: cnt_o = preset_i;
            VIEW_REG:    cnt_o = cnt_q;
            default:     cnt_o = cnt_q;
        endcase
    end

    p_dec_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && step == STEP_DEC && cnt_q != '0) |=> (!aload_n || cnt_q == $past(cnt_q) - ONE));

    p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && step == STEP_HOLD) |=> (!aload_n || $stable(cnt_q)));

    p_sload_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && step == STEP_LOAD) |=> (!aload_n || cnt_q == $past(preset_i)));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (aload_n && step == STEP_DEC && cnt_q == '0) |=> (!aload_n || cnt_q == MAXV));
endmodule

// File: rtl/dcnt_zero_det.sv
module dcnt_zero_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         en_n,
    output logic         tc_n
);
    localparam int NG = (W + 3) / 4;

    logic [NG-1:0] grp_nz;

    // Nibble-wide any-one groups, then a final OR
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * 4;
        localparam int HI = (LO + 3 < W) ? LO + 3 : W - 1;
        assign grp_nz[g] = |cnt_i[HI:LO];
    end

    assign tc_n = (|grp_nz) | en_n;
endmodule

// File: rtl/dcnt_stage.sv
module dcnt_stage
    import dcnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         aload_n,
    input  logic         sload_n,
    input  logic         en_n,
    input  logic [W-1:0] preset_i,
    output logic         tc_n,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] MAXV = '1;

    step_e step;
    view_e view;

    dcnt_mode_dec u_dec (
        .clr_n   (clr_n),
        .aload_n (aload_n),
        .sload_n (sload_n),
        .en_n    (en_n),
        .step    (step),
        .view    (view)
    );

    dcnt_core #(.W(W)) u_core (
        .clk      (clk),
        .clr_n    (clr_n),
        .aload_n  (aload_n),
        .step     (step),
        .view     (view),
        .preset_i (preset_i),
        .cnt_o    (count_o)
    );

    dcnt_zero_det #(.W(W)) u_zero (
        .cnt_i (count_o),
        .en_n  (en_n),
        .tc_n  (tc_n)
    );

    // Clear is the reset of this block, so it cannot disable its own check
    p_clr_r1: assert property (@(posedge clk)
        !clr_n |-> (count_o == MAXV && step != STEP_LOAD || count_o == MAXV));

    p_prec_r6: assert property (@(posedge clk)
        (!clr_n && !aload_n) |-> count_o == MAXV);

    p_aload_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !aload_n |-> count_o == preset_i);

    p_tc_r7: assert property (@(posedge clk) disable iff (!clr_n)
        !tc_n |-> (count_o == '0 && !en_n));
endmodule

// File: tb/dcnt_stage_test.sv
`timescale 1ns/1ps
module dcnt_stage_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0, aload_n = 1'b1, sload_n = 1'b1, en_n = 1'b1;
    logic [7:0] preset = 8'h00;
    logic       tc_n;
    logic [7:0] count;

    logic       ch_clr_n = 1'b0, ch_en_n = 1'b1;
    logic       lo_tc_n, hi_tc_n;
    logic [7:0] lo_cnt, hi_cnt;

    int    ref_q = 255;
    int    n_cmp = 0, n_bad = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dcnt_stage #(.W(8)) uut (
        .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
        .en_n(en_n), .preset_i(preset), .tc_n(tc_n), .count_o(count)
    );

    dcnt_stage #(.W(8)) u_lo (
        .clk(clk), .clr_n(ch_clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(ch_en_n), .preset_i(8'h00), .tc_n(lo_tc_n), .count_o(lo_cnt)
    );

    dcnt_stage #(.W(8)) u_hi (
        .clk(clk), .clr_n(ch_clr_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(lo_tc_n), .preset_i(8'h00), .tc_n(hi_tc_n), .count_o(hi_cnt)
    );

    // Behavioural reference of the stored count
    always @(posedge clk or negedge clr_n or negedge aload_n) begin
        if (!clr_n)        ref_q = 255;
        else if (!aload_n) ref_q = int'(preset);
        else if (!sload_n) ref_q = int'(preset);
        else if (!en_n)    ref_q = (ref_q + 255) % 256;
    end

    function automatic int exp_cnt();
        if (!clr_n)   return 255;
        if (!aload_n) return int'(preset);
        return ref_q;
    endfunction

    function automatic int exp_tc();
        return (exp_cnt() == 0 && !en_n) ? 0 : 1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check(cur_req, "count", int'(count), exp_cnt());
            check("R7", "tc_n", int'(tc_n), exp_tc());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int first, second;
        // R1: clear holds max whatever the other controls do
        #1;
        check("R1", "clear at start", int'(count), 255);
        sload_n = 1'b0; en_n = 1'b0; preset = 8'h12;
        tick(); tick();
        check("R1", "clear beats sload", int'(count), 255);
        sload_n = 1'b1; en_n = 1'b1;
        tick();

        // R2: decrement
        cur_req = "R2";
        clr_n = 1'b1; en_n = 1'b0;
        repeat (10) tick();
        check("R2", "ten decrements", int'(count), 245);

        // R3: hold
        cur_req = "R3";
        en_n = 1'b1;
        repeat (5) tick();
        check("R3", "hold", int'(count), 245);

        // R4: synchronous load with enable off and on
        cur_req = "R4";
        preset = 8'h5A; sload_n = 1'b0;
        tick();
        check("R4", "sload en high", int'(count), 8'h5A);
        en_n = 1'b0; preset = 8'h20;
        tick();
        check("R4", "sload en low", int'(count), 8'h20);
        sload_n = 1'b1;
        tick();
        check("R4", "count after sload", int'(count), 8'h1F);

        // R5: asynchronous load follows preset, ignores clock/enable/sload
        cur_req = "R5";
        en_n = 1'b1; preset = 8'h33; aload_n = 1'b0;
        #0.5;
        check("R5", "aload immediate", int'(count), 8'h33);
        preset = 8'h77;
        #0.5;
        check("R5", "aload tracks preset", int'(count), 8'h77);
        sload_n = 1'b0; en_n = 1'b0;
        tick(); tick();
        check("R5", "aload held over edges", int'(count), 8'h77);
        sload_n = 1'b1; en_n = 1'b1; aload_n = 1'b1;
        tick();
        check("R5", "kept after release", int'(count), 8'h77);
        en_n = 1'b0;
        tick();
        check("R5", "counts after release", int'(count), 8'h76);

        // R6: precedence
        cur_req = "R6";
        en_n = 1'b1; preset = 8'h10; clr_n = 1'b0; aload_n = 1'b0;
        #1;
        check("R6", "clear beats aload", int'(count), 255);
        tick();
        clr_n = 1'b1;
        #1;
        check("R6", "aload after clear release", int'(count), 8'h10);
        tick();
        aload_n = 1'b1; sload_n = 1'b0; preset = 8'h44; clr_n = 1'b0;
        tick();
        check("R6", "clear beats sload", int'(count), 255);
        clr_n = 1'b1; en_n = 1'b0;
        tick();
        check("R6", "sload beats enable", int'(count), 8'h44);
        sload_n = 1'b1; en_n = 1'b1;

        // R7: terminal output gated by enable, combinational
        cur_req = "R7";
        preset = 8'h03; sload_n = 1'b0;
        tick();
        sload_n = 1'b1; en_n = 1'b0;
        repeat (3) tick();
        check("R7", "tc low at zero", int'(tc_n), 0);
        en_n = 1'b1;
        #1;
        check("R7", "tc follows enable", int'(tc_n), 1);
        preset = 8'h00; en_n = 1'b0; aload_n = 1'b1;
        tick();
        check("R8", "wrap to max", int'(count), 255);
        aload_n = 1'b0;
        #1;
        check("R7", "tc after aload zero", int'(tc_n), 0);
        tick();
        aload_n = 1'b1;

        // R8: free-running period of 256
        cur_req = "R8";
        first = 0;
        for (int i = 1; i <= 300; i++) begin
            tick();
            if (!tc_n && first == 0) first = i;
        end
        check("R8", "wrap period", first, 256);

        // R9: two-stage cascade
        cur_req = "R3";
        en_n = 1'b1;
        ch_clr_n = 1'b0;
        tick();
        ch_clr_n = 1'b1; ch_en_n = 1'b0;
        first = 0; second = 0;
        for (int j = 1; j <= 140000; j++) begin
            @(negedge clk);
            if (!hi_tc_n) begin
                if (first == 0) first = j;
                else if (second == 0) second = j;
            end
            if (second != 0) break;
        end
        check("R9", "first chain terminal", first, 65536);
        check("R9", "chain period", second - first, 65536);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule